// File: doc/BRIEF.md
# Two-Port SATA Host Register File

This block is the memory-mapped register file of a two-port SATA host controller. It takes single 32-bit register accesses inside a 4 KB window. It holds a small set of global registers and one bank of registers for each port. Software writes the command list and receive-area base addresses, the interrupt mask and the port command word. Software reads back status, and it clears interrupt causes by writing ones to them. A command engine beside the block reports per-port interrupt causes on a set-bit vector. The block folds each port's enabled causes into a sticky global status vector and drives one level-sensitive interrupt line from that vector.

When software starts a port, or issues commands on a port that is already started, the block arms a per-port delay counter. When the counter runs out, the block sends a one-cycle kick to the command engine. A new qualifying write restarts the count from the beginning. A write of the reset bit in global control returns every port register to zero and cancels any pending kick.

The request side has no back-pressure. Every request is accepted in the cycle it is presented. A read answers with `rsp_valid` and the data exactly one cycle later, and a write produces no response.

Top module: `sata_host_regs`

## Requirements
- R1: After reset, the global registers read as follows: capabilities (0x000) = 0x00001F02, holding the port count 2 in bits 4:0 and a slot-count field of 0x1F in bits 12:8; interrupt status (0x008) = 0; ports implemented (0x00C) = 0x1; version (0x010) = 0x00010100. Any other offset below 0x020 reads 0. Offsets from 0x020 to 0x0FF read 0, and offsets from 0x200 up to 0xFFF read 0.
- R2: Port n's bank starts at 0x100 + n*0x80. The words at in-bank offsets 0x00, 0x04, 0x08, 0x0C, 0x14, 0x1C, 0x20, 0x24, 0x2C, 0x30, 0x34 and 0x38 store what is written and read it back. In-bank offsets 0x3C to 0x7F read 0 and ignore writes. Port banks are independent of each other.
- R3: A read request returns `rsp_valid`=1 and its data in the next cycle. A write request never raises `rsp_valid`.
- R4: The port interrupt status at in-bank offset 0x10 sets the bits given on that port's 32-bit slice of `port_evt`. A write clears exactly the bits written as 1. When an event bit and a clearing write hit the same bit in the same cycle, the set wins.
- R5: Global status bit n (offset 0x008) becomes 1 one cycle after port n's (status AND mask) is nonzero. `irq` is 1 exactly while the global status is nonzero.
- R6: Writing the global status clears the bits written as 1. A bit whose port still has an enabled cause set comes back one cycle later.
- R7: The port command word (in-bank 0x18) keeps only bits 24, 15, 14, 4, 3, 2, 1 and 0. Every other bit reads 0.
- R8: A write to the command word with bit 0 set, or a write to command issue (in-bank 0x38) while the stored command bit 0 is 1, raises that port's `port_kick` for one cycle, KICK_DELAY cycles after the write edge. A later qualifying write restarts the count.
- R9: SStatus (in-bank 0x28) reads 3 for port 0 while `drive_present` is 1, and 0 in every other case. Writes to it are ignored.
- R10: A write whose address has bit 1 or bit 0 set changes no register.
- R11: Global control (0x004) reads 0x80000000. Writing it with bit 0 = 1 clears every port register, including status, command and command issue, and cancels pending kicks.
- R12: Capabilities, ports implemented and version ignore writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Register access request, accepted in the same cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 12 | Byte address inside the 4 KB window |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid, one cycle after a read request |
| rsp_rdata | output | 32 | Read data |
| port_evt | input | NPORTS*32 | Per-port interrupt cause set bits, port n in slice n |
| drive_present | input | 1 | A drive is attached to port 0 |
| irq | output | 1 | Level interrupt, high while global status is nonzero |
| port_kick | output | NPORTS | One-cycle request to process commands, one bit per port |

## Verification
The assertions run on every cycle. They check that a clearing write leaves none of its bits set in port status when no event arrives in the same cycle, that an enabled pending cause always sets its global bit, that `irq` only rises after a pending cause, that a kick never lasts two cycles, that a soft reset empties the status, and that a misaligned write enables no register. The scenarios in the bench show the absolute reset values, the command-word mask, the synthesized SStatus, the exact kick latency and its restart, the set-wins collision, the re-setting of a cleared global bit that is still pending, and the cancelling of a pending kick by a soft reset.

// File: rtl/shr_pkg.sv
package shr_pkg;
  localparam int ADDR_W = 12;
  localparam int DATA_W = 32;

  // per-port register word index (in-bank offset >> 2)
  localparam logic [3:0] IDX_CLB  = 4'd0;
  localparam logic [3:0] IDX_IS   = 4'd4;
  localparam logic [3:0] IDX_IE   = 4'd5;
  localparam logic [3:0] IDX_CMD  = 4'd6;
  localparam logic [3:0] IDX_SSTS = 4'd10;
  localparam logic [3:0] IDX_CI   = 4'd14;
  localparam int         NREG     = 15;

  // bits the command word keeps
  localparam logic [DATA_W-1:0] CMD_KEEP = 32'h0100_C01F;

  // global register word index (offset >> 2)
  localparam logic [2:0] G_CAP  = 3'd0;
  localparam logic [2:0] G_CTL  = 3'd1;
  localparam logic [2:0] G_STAT = 3'd2;
  localparam logic [2:0] G_PI   = 3'd3;
  localparam logic [2:0] G_VER  = 3'd4;

  localparam logic [DATA_W-1:0] CTL_VALUE = 32'h8000_0000;
endpackage

// File: rtl/shr_port_bank.sv
module shr_port_bank
  import shr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_rst,
  input  logic              wr_en,
  input  logic [4:0]        wr_word,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [4:0]        rd_word,
  input  logic [DATA_W-1:0] evt_set,
  input  logic              link_up,
  output logic [DATA_W-1:0] rd_data,
  output logic              pending,
  output logic              kick_req
);
  logic [DATA_W-1:0] regs_q [NREG];
  logic              wr_hit;
  logic [3:0]        widx;
  logic [DATA_W-1:0] clr_mask;
  logic [DATA_W-1:0] stat_q;
  logic [DATA_W-1:0] mask_q;
  logic [DATA_W-1:0] cmd_q;

  assign widx     = wr_word[3:0];
  assign wr_hit   = wr_en && !wr_word[4] && (widx != 4'hF);
  assign clr_mask = (wr_hit && widx == IDX_IS) ? wr_data : '0;
  assign stat_q   = regs_q[IDX_IS];
  assign mask_q   = regs_q[IDX_IE];
  assign cmd_q    = regs_q[IDX_CMD];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) regs_q[i] <= '0;
    end else if (soft_rst) begin
      for (int i = 0; i < NREG; i++) regs_q[i] <= '0;
    end else begin
      for (int i = 0; i < NREG; i++) begin
        if (wr_hit && widx == 4'(i)) regs_q[i] <= wr_data;
      end
      // special words override the plain store
      regs_q[IDX_SSTS] <= '0;
      if (wr_hit && widx == IDX_CMD) regs_q[IDX_CMD] <= wr_data & CMD_KEEP;
      regs_q[IDX_IS] <= (stat_q & ~clr_mask) | evt_set;
    end
  end

  assign pending  = |(stat_q & mask_q);
  assign kick_req = wr_hit && ((widx == IDX_CMD && wr_data[0]) ||
                               (widx == IDX_CI && cmd_q[0]));

  always_comb begin
    if (rd_word[4] || rd_word[3:0] == 4'hF) rd_data = '0;
    else if (rd_word[3:0] == IDX_SSTS)      rd_data = {30'd0, link_up, link_up};
    else                                     rd_data = regs_q[rd_word[3:0]];
  end

  AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit && widx == IDX_IS && evt_set == '0 && !soft_rst)
      |=> ((stat_q & $past(wr_data)) == '0)); // R4

  AST_SOFT_RESET_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (stat_q == '0 && cmd_q == '0)); // R11
endmodule

// File: rtl/shr_kick_timer.sv
module shr_kick_timer #(
  parameter int DELAY = 125000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic restart,
  output logic kick
);
  localparam int CW = $clog2(DELAY + 1);
  localparam logic [CW-1:0] LOAD = CW'(DELAY);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      kick  <= 1'b0;
    end else if (clear) begin
      cnt_q <= '0;
      kick  <= 1'b0;
    end else if (restart) begin
      cnt_q <= LOAD;
      kick  <= 1'b0;
    end else begin
      kick <= (cnt_q == CW'(1));
      if (cnt_q != '0) cnt_q <= cnt_q - CW'(1);
    end
  end

  AST_KICK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    kick |=> !kick); // R8
endmodule

// File: rtl/shr_irq_merge.sv
module shr_irq_merge #(
  parameter int NPORTS = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NPORTS-1:0] pend,
  input  logic              clr_we,
  input  logic [NPORTS-1:0] clr_bits,
  output logic [NPORTS-1:0] gstat,
  output logic              irq
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) gstat <= '0;
    else        gstat <= (gstat & ~(clr_we ? clr_bits : '0)) | pend;
  end

  assign irq = |gstat;

  for (genvar p = 0; p < NPORTS; p++) begin : g_chk
    AST_PEND_SETS_GLOBAL: assert property (@(posedge clk) disable iff (!rst_n)
      pend[p] |=> gstat[p]); // R5
  end

  AST_IRQ_NEEDS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(|pend)); // R5
endmodule

// File: rtl/sata_host_regs.sv
module sata_host_regs
  import shr_pkg::*;
#(
  parameter int              NPORTS     = 2,
  parameter int              KICK_DELAY = 125000,
  parameter logic [31:0]     PORTS_IMPL = 32'h0000_0001,
  parameter logic [31:0]     VERSION    = 32'h0001_0100
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req_valid,
  input  logic                     req_write,
  input  logic [11:0]              req_addr,
  input  logic [31:0]              req_wdata,
  output logic                     rsp_valid,
  output logic [31:0]              rsp_rdata,
  input  logic [NPORTS*32-1:0]     port_evt,
  input  logic                     drive_present,
  output logic                     irq,
  output logic [NPORTS-1:0]        port_kick
);
  localparam int PIDX_W = (NPORTS > 1) ? $clog2(NPORTS) : 1;
  localparam logic [ADDR_W-1:0] BANK_BASE = 12'h100;
  localparam logic [ADDR_W-1:0] BANK_END  = ADDR_W'(32'h100 + NPORTS * 32'h80);
  localparam logic [DATA_W-1:0] CAP_VALUE = 32'h0000_1F00 | DATA_W'(NPORTS);

  logic              aligned, wr_ok, g_sel, in_bank;
  logic [2:0]        g_word;
  logic [ADDR_W-1:0] bank_off;
  logic [PIDX_W-1:0] bank_idx;
  logic              soft_rst, gclr_we;
  logic [NPORTS-1:0] bank_we, pend, kick_req, gstat;
  logic [DATA_W-1:0] bank_rd [NPORTS];
  logic [DATA_W-1:0] rd_next;

  assign aligned  = (req_addr[1:0] == 2'b00);
  assign wr_ok    = req_valid && req_write && aligned;
  assign g_sel    = (req_addr < 12'h020);
  assign g_word   = req_addr[4:2];
  assign in_bank  = (req_addr >= BANK_BASE) && (req_addr < BANK_END);
  assign bank_off = req_addr - BANK_BASE;
  assign bank_idx = PIDX_W'(bank_off >> 7);
  assign soft_rst = wr_ok && g_sel && (g_word == G_CTL) && req_wdata[0];
  assign gclr_we  = wr_ok && g_sel && (g_word == G_STAT);

  for (genvar p = 0; p < NPORTS; p++) begin : g_port
    logic link;
    if (p == 0) begin : g_link0
      assign link = drive_present;
    end else begin : g_linkn
      assign link = 1'b0;
    end

    assign bank_we[p] = wr_ok && in_bank && (bank_idx == PIDX_W'(p));

    shr_port_bank u_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .soft_rst (soft_rst),
      .wr_en    (bank_we[p]),
      .wr_word  (req_addr[6:2]),
      .wr_data  (req_wdata),
      .rd_word  (req_addr[6:2]),
      .evt_set  (port_evt[p*32 +: 32]),
      .link_up  (link),
      .rd_data  (bank_rd[p]),
      .pending  (pend[p]),
      .kick_req (kick_req[p])
    );

    shr_kick_timer #(.DELAY(KICK_DELAY)) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .clear   (soft_rst),
      .restart (kick_req[p]),
      .kick    (port_kick[p])
    );
  end

  shr_irq_merge #(.NPORTS(NPORTS)) u_merge (
    .clk      (clk),
    .rst_n    (rst_n),
    .pend     (pend),
    .clr_we   (gclr_we),
    .clr_bits (req_wdata[NPORTS-1:0]),
    .gstat    (gstat),
    .irq      (irq)
  );

  always_comb begin
    rd_next = '0;
    if (g_sel) begin
      case (g_word)
        G_CAP:   rd_next = CAP_VALUE;
        G_CTL:   rd_next = CTL_VALUE;
        G_STAT:  rd_next = {{(DATA_W-NPORTS){1'b0}}, gstat};
        G_PI:    rd_next = PORTS_IMPL;
        G_VER:   rd_next = VERSION;
        default: rd_next = '0;
      endcase
    end else if (in_bank) begin
      rd_next = bank_rd[bank_idx];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= req_valid && !req_write;
      if (req_valid && !req_write) rsp_rdata <= rd_next;
    end
  end

  AST_MISALIGNED_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && !aligned)
      |-> (bank_we == '0 && !soft_rst && !gclr_we)); // R10

  AST_WRITE_NO_RESPONSE: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write) |=> !rsp_valid); // R3
endmodule

// File: tb/sata_host_regs_tb.sv
module sata_host_regs_tb;
  localparam int NP = 2;
  localparam int D  = 16;
  localparam int NV = 30;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0, req_write = 1'b0;
  logic [11:0]   req_addr = '0;
  logic [31:0]   req_wdata = '0;
  logic          rsp_valid;
  logic [31:0]   rsp_rdata;
  logic [NP*32-1:0] port_evt = '0;
  logic          drive_present = 1'b1;
  logic          irq;
  logic [NP-1:0] port_kick;

  int n_chk = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  sata_host_regs #(.NPORTS(NP), .KICK_DELAY(D)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata), .port_evt(port_evt), .drive_present(drive_present),
    .irq(irq), .port_kick(port_kick)
  );

  // {req number, write, address, data, expected read}
  localparam logic [80:0] VEC [NV] = '{
    {4'd1, 1'b0, 12'h000, 32'h0, 32'h0000_1F02},   // R1 capabilities
    {4'd11,1'b0, 12'h004, 32'h0, 32'h8000_0000},   // R11 global control
    {4'd1, 1'b0, 12'h008, 32'h0, 32'h0},           // R1
    {4'd1, 1'b0, 12'h00C, 32'h0, 32'h1},           // R1
    {4'd1, 1'b0, 12'h010, 32'h0, 32'h0001_0100},   // R1
    {4'd1, 1'b0, 12'h018, 32'h0, 32'h0},           // R1
    {4'd1, 1'b0, 12'h080, 32'h0, 32'h0},           // R1
    {4'd1, 1'b0, 12'h200, 32'h0, 32'h0},           // R1
    {4'd1, 1'b0, 12'hFFC, 32'h0, 32'h0},           // R1
    {4'd2, 1'b1, 12'h100, 32'h1234_5678, 32'h0},   // R2
    {4'd2, 1'b0, 12'h100, 32'h0, 32'h1234_5678},   // R2
    {4'd2, 1'b1, 12'h184, 32'hCAFE_F00D, 32'h0},   // R2
    {4'd2, 1'b0, 12'h184, 32'h0, 32'hCAFE_F00D},   // R2
    {4'd2, 1'b0, 12'h104, 32'h0, 32'h0},           // R2
    {4'd2, 1'b0, 12'h1A4, 32'h0, 32'h0},           // R2
    {4'd7, 1'b1, 12'h118, 32'hFFFF_FFFE, 32'h0},   // R7
    {4'd7, 1'b0, 12'h118, 32'h0, 32'h0100_C01E},   // R7
    {4'd9, 1'b1, 12'h128, 32'h0000_FFFF, 32'h0},   // R9
    {4'd9, 1'b0, 12'h128, 32'h0, 32'h3},           // R9
    {4'd9, 1'b0, 12'h1A8, 32'h0, 32'h0},           // R9
    {4'd10,1'b1, 12'h102, 32'hFFFF_FFFF, 32'h0},   // R10
    {4'd10,1'b0, 12'h100, 32'h0, 32'h1234_5678},   // R10
    {4'd12,1'b1, 12'h000, 32'hFFFF_FFFF, 32'h0},   // R12
    {4'd12,1'b0, 12'h000, 32'h0, 32'h0000_1F02},   // R12
    {4'd12,1'b1, 12'h00C, 32'h0, 32'h0},           // R12
    {4'd12,1'b0, 12'h00C, 32'h0, 32'h1},           // R12
    {4'd2, 1'b1, 12'h13C, 32'h5, 32'h0},           // R2
    {4'd2, 1'b0, 12'h13C, 32'h0, 32'h0},           // R2
    {4'd2, 1'b1, 12'h1AC, 32'h77, 32'h0},          // R2
    {4'd2, 1'b0, 12'h1AC, 32'h0, 32'h77}           // R2
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic bus_rd(input logic [11:0] a, output logic [31:0] d, output logic v);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    @(negedge clk);
    d = rsp_rdata; v = rsp_valid;
    req_valid = 1'b0;
  endtask

  task automatic rd_chk(input string tag, input logic [11:0] a, input logic [31:0] exp);
    logic [31:0] d;
    logic v;
    bus_rd(a, d, v);
    chk(tag, d, exp);
  endtask

  task automatic pulse_evt(input int port, input logic [31:0] bits);
    @(negedge clk);
    port_evt[port*32 +: 32] = bits;
    @(negedge clk);
    port_evt = '0;
  endtask

  // counts kicks on one port over a window; first = cycle of the first kick
  task automatic watch_kick(input int port, output int first, output int count);
    first = -1; count = 0;
    for (int k = 1; k <= D + 4; k++) begin
      @(negedge clk);
      if (port_kick[port]) begin
        count++;
        if (first < 0) first = k;
      end
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    logic [31:0] d;
    logic v;
    int first, count;

    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state of outputs
    chk("R1 irq at reset", {31'd0, irq}, 32'd0);
    chk("R1 kick at reset", {30'd0, port_kick}, 32'd0);
    chk("R3 rsp_valid at reset", {31'd0, rsp_valid}, 32'd0);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][76]) bus_wr(VEC[i][75:64], VEC[i][63:32]);
      else begin
        bus_rd(VEC[i][75:64], d, v);
        n_chk++;
        if (d !== VEC[i][31:0]) begin
          n_fail++;
          $display("FAIL R%0d vector %0d actual=%h expected=%h",
                   VEC[i][80:77], i, d, VEC[i][31:0]);
        end
      end
    end

    // R3 response timing
    bus_rd(12'h010, d, v);
    chk("R3 read valid next cycle", {31'd0, v}, 32'd1);
    bus_wr(12'h11C, 32'hA5);
    chk("R3 no response to write", {31'd0, rsp_valid}, 32'd0);
    rd_chk("R2 spare word", 12'h11C, 32'hA5);

    // R9 no drive
    drive_present = 1'b0;
    rd_chk("R9 SStatus without drive", 12'h128, 32'h0);
    drive_present = 1'b1;

    // R5 aggregation on port 1
    bus_wr(12'h194, 32'h1);
    pulse_evt(1, 32'h1);
    @(negedge clk);
    chk("R5 irq raised", {31'd0, irq}, 32'd1);
    rd_chk("R5 global status", 12'h008, 32'h2);
    rd_chk("R4 port1 status set", 12'h190, 32'h1);

    // R4 clear port status; R6 global sticky, then cleared
    bus_wr(12'h190, 32'h1);
    rd_chk("R4 port1 status cleared", 12'h190, 32'h0);
    chk("R6 global stays set", {31'd0, irq}, 32'd1);
    bus_wr(12'h008, 32'h2);
    @(negedge clk);
    rd_chk("R6 global cleared", 12'h008, 32'h0);
    chk("R5 irq dropped", {31'd0, irq}, 32'd0);

    // R6 re-set while still pending on port 0
    bus_wr(12'h114, 32'h8);
    pulse_evt(0, 32'h8);
    @(negedge clk);
    bus_wr(12'h008, 32'h1);
    rd_chk("R6 pending bit comes back", 12'h008, 32'h1);
    bus_wr(12'h110, 32'h8);
    bus_wr(12'h008, 32'h1);
    @(negedge clk);
    rd_chk("R6 cleared after cause cleared", 12'h008, 32'h0);
    chk("R5 irq low", {31'd0, irq}, 32'd0);

    // R4 set wins over clear in the same cycle
    @(negedge clk);
    port_evt[31:0] = 32'h10;
    req_valid = 1'b1; req_write = 1'b1; req_addr = 12'h110; req_wdata = 32'h10;
    @(negedge clk);
    port_evt = '0; req_valid = 1'b0; req_write = 1'b0;
    rd_chk("R4 set wins", 12'h110, 32'h10);
    pulse_evt(0, 32'h20);
    rd_chk("R4 second cause", 12'h110, 32'h30);
    bus_wr(12'h110, 32'h20);
    rd_chk("R4 partial clear", 12'h110, 32'h10);
    bus_wr(12'h112, 32'hFFFF_FFFF);
    rd_chk("R10 misaligned clear ignored", 12'h110, 32'h10);

    // R8 kick from start
    bus_wr(12'h118, 32'h1);
    watch_kick(0, first, count);
    chk("R8 kick latency", first, D);
    chk("R8 kick width", count, 1);
    // R8 restart by command issue
    bus_wr(12'h138, 32'h1);
    repeat (5) @(negedge clk);
    bus_wr(12'h138, 32'h3);
    watch_kick(0, first, count);
    chk("R8 restarted latency", first, D);
    chk("R8 restarted count", count, 1);
    // R8 issue on a stopped port gives no kick
    bus_wr(12'h1B8, 32'h1);
    watch_kick(1, first, count);
    chk("R8 stopped port no kick", count, 0);

    // R11 soft reset cancels kick and clears ports
    bus_wr(12'h118, 32'h1);
    bus_wr(12'h004, 32'h1);
    watch_kick(0, first, count);
    chk("R11 pending kick cancelled", count, 0);
    rd_chk("R11 base cleared", 12'h100, 32'h0);
    rd_chk("R11 status cleared", 12'h110, 32'h0);
    rd_chk("R11 command cleared", 12'h118, 32'h0);
    rd_chk("R11 port1 word cleared", 12'h184, 32'h0);
    rd_chk("R11 control readback", 12'h004, 32'h8000_0000);
    rd_chk("R12 capabilities kept", 12'h000, 32'h0000_1F02);

    finish_run();
  end
endmodule